// File: doc/BRIEF.md
# Trigger Holdoff Gate

This block sits between a raw trigger comparator and the acquisition controller. It turns every rising edge of the raw trigger into a single one-cycle qualified pulse. After each pulse it passes, it blocks further triggers for a programmed holdoff. The raw trigger can come from the input signal, an internal source, an external input or backplane TTL lines, with either slope already applied; all of them go through this gate the same way.

The holdoff is set by a 16-bit value and is read in one of two ways. In event mode the value is a count of raw trigger edges that are rejected after a pass, from 1 to 65535 with one-edge resolution. In time mode the value is a count of 100 ns ticks from a 10 MHz strobe, giving 100 ns to about 6.5 ms. One down-counter serves both modes. It is loaded on each passed trigger and cleared whenever the gate is disabled, so a new mode or value written while disabled starts from a clean state.

Top module: `hold_trigger_gate`

## Requirements
- R1: While reset is asserted and right after it, `trigOut` and `holdActive` are 0.
- R2: A raw rising edge that is accepted gives exactly one `trigOut` pulse, one cycle wide, in the cycle after the edge is first sampled high. A raw trigger that stays high for many cycles still gives only one pulse.
- R3: While `enable` is 0, no pulse is produced, `holdActive` is 0 from the next cycle on, and the holdoff state is cleared. The first edge after re-enabling therefore passes.
- R4: In event mode (`modeTime`=0) with value N, the first edge passes, the next N raw edges are discarded, and the edge after those passes. `tick` has no effect in this mode.
- R5: In time mode (`modeTime`=1) with value N, edges are discarded until N `tick` strobes have been seen after the pass, and the next edge passes. Raw edges do not shorten the holdoff in this mode.
- R6: A value of 0 means no holdoff, so every rising edge passes.
- R7: `holdActive` is 1 from the cycle after a pass with a nonzero value until the holdoff count reaches 0.
- R8: In time mode, an edge that arrives in the same cycle as the final tick is discarded, because the decision uses the count held before that cycle's update.
- R9: The value is captured when a trigger passes. Changing `holdVal` during a running holdoff does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigRaw | input | 1 | Raw trigger level from the comparator |
| modeTime | input | 1 | 0 = holdoff counted in events, 1 = counted in ticks |
| holdVal | input | 16 | Holdoff length, in events or 100 ns ticks |
| enable | input | 1 | Gate enable; low clears the holdoff state |
| tick | input | 1 | One-cycle 10 MHz time strobe |
| trigOut | output | 1 | Qualified trigger pulse |
| holdActive | output | 1 | High while a holdoff is running |

## Verification
The assertions check on every cycle that pulses are never back to back, that a disabled gate produces neither pulses nor an active holdoff, that the counter is never decremented at zero, that a pass raises `holdActive` exactly when the captured value is nonzero, and that a time-mode holdoff ends only on a tick. The exact event and tick counts that separate a discarded edge from a passed one, the tie between the last tick and an edge, and the capture of the value at pass time can only be shown by the bench's directed scenarios.

// File: rtl/hold_pkg.sv
package hold_pkg;
  typedef struct packed {
    logic load;
    logic dec;
    logic clear;
  } holdCmd_t;
endpackage

// File: rtl/hold_datapath.sv
module hold_datapath
  import hold_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigRaw,
  input  holdCmd_t         cmd,
  input  logic [CNT_W-1:0] loadVal,
  output logic             rise,
  output logic             cntZero
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             trigPrev;
  logic [CNT_W-1:0] holdCnt;

  always_ff @(posedge clk) begin
    if (!rstN) trigPrev <= 1'b0;
    else       trigPrev <= trigRaw;
  end

  assign rise = trigRaw & ~trigPrev;

  always_ff @(posedge clk) begin
    if (!rstN)          holdCnt <= '0;
    else if (cmd.clear) holdCnt <= '0;
    else if (cmd.load)  holdCnt <= loadVal;
    else if (cmd.dec)   holdCnt <= holdCnt - CNT_ONE;
  end

  assign cntZero = (holdCnt == '0);

  // R4
  dec_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.dec |-> !cntZero);

  // R3
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clear |=> cntZero);
endmodule

// File: rtl/hold_control.sv
module hold_control
  import hold_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     modeTime,
  input  logic     tick,
  input  logic     rise,
  input  logic     cntZero,
  output holdCmd_t cmd,
  output logic     trigOut
);
  logic pass;
  logic stepEvt;

  assign pass    = enable & rise & cntZero;
  assign stepEvt = modeTime ? tick : rise;

  always_comb begin
    cmd       = '0;
    cmd.clear = ~enable;
    cmd.load  = pass;
    cmd.dec   = enable & ~cntZero & stepEvt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) trigOut <= 1'b0;
    else       trigOut <= pass;
  end

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |=> !trigOut);

  // R3
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !trigOut);
endmodule

// File: rtl/hold_trigger_gate.sv
module hold_trigger_gate
  import hold_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigRaw,
  input  logic             modeTime,
  input  logic [CNT_W-1:0] holdVal,
  input  logic             enable,
  input  logic             tick,
  output logic             trigOut,
  output logic             holdActive
);
  holdCmd_t cmd;
  logic     rise;
  logic     cntZero;

  hold_datapath #(.CNT_W(CNT_W)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .trigRaw (trigRaw),
    .cmd     (cmd),
    .loadVal (holdVal),
    .rise    (rise),
    .cntZero (cntZero)
  );

  hold_control i_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .modeTime (modeTime),
    .tick     (tick),
    .rise     (rise),
    .cntZero  (cntZero),
    .cmd      (cmd),
    .trigOut  (trigOut)
  );

  assign holdActive = ~cntZero;

  // R7
  pass_arms_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |-> (holdActive == ($past(holdVal) != '0)));

  // R3
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !holdActive);

  // R5
  time_ends_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(holdActive) && $past(enable) && $past(modeTime)) |-> $past(tick));
endmodule

// File: tb/test_hold_trigger_gate.sv
module test_hold_trigger_gate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trigRaw = 1'b0;
  logic        modeTime = 1'b0;
  logic [15:0] holdVal = '0;
  logic        enable = 1'b0;
  logic        tick = 1'b0;
  logic        trigOut;
  logic        holdActive;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  hold_trigger_gate i_hold_trigger_gate (
    .clk        (clk),
    .rstN       (rstN),
    .trigRaw    (trigRaw),
    .modeTime   (modeTime),
    .holdVal    (holdVal),
    .enable     (enable),
    .tick       (tick),
    .trigOut    (trigOut),
    .holdActive (holdActive)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one raw pulse of one cycle; got = trigOut seen after the edge
  task automatic fire(output logic got);
    @(negedge clk) trigRaw = 1'b1;
    @(negedge clk) got = trigOut;
    trigRaw = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic cfg(input logic m, input logic [15:0] v);
    @(negedge clk) enable = 1'b0;
    modeTime = m;
    holdVal = v;
    @(negedge clk) enable = 1'b1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 trigOut in reset", trigOut, 0);
    chk("R1 holdActive in reset", holdActive, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 trigOut after reset", trigOut, 0);
    chk("R1 holdActive after reset", holdActive, 0);
  endtask

  task automatic t_long_high;
    int seen;
    cfg(1'b0, 16'd0);
    seen = 0;
    @(negedge clk) trigRaw = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (trigOut) seen++;
      if (i == 0) chk("R2 pulse one cycle after edge", trigOut, 1);
    end
    trigRaw = 1'b0;
    @(negedge clk);
    chk("R2 one pulse for long high", seen, 1);
  endtask

  task automatic t_no_hold;
    logic g;
    cfg(1'b0, 16'd0);
    for (int i = 0; i < 3; i++) begin
      fire(g);
      chk("R6 zero value passes every edge", g, 1);
    end
    chk("R6 no holdoff active", holdActive, 0);
  endtask

  task automatic t_event;
    logic g;
    cfg(1'b0, 16'd3);
    fire(g);
    chk("R4 first edge passes", g, 1);
    chk("R7 active after pass", holdActive, 1);
    for (int i = 0; i < 3; i++) begin
      fire(g);
      chk("R4 edge discarded", g, 0);
      if (i == 1) chk("R7 still active mid holdoff", holdActive, 1);
    end
    chk("R7 inactive after N discards", holdActive, 0);
    fire(g);
    chk("R4 edge after N discards passes", g, 1);
    // ticks do not count in event mode
    cfg(1'b0, 16'd1);
    fire(g);
    ticks(5);
    chk("R4 tick ignored in event mode", holdActive, 1);
    fire(g);
    chk("R4 discarded after ticks", g, 0);
    fire(g);
    chk("R4 passes after one discard", g, 1);
  endtask

  task automatic t_time;
    logic g;
    cfg(1'b1, 16'd3);
    fire(g);
    chk("R5 first edge passes", g, 1);
    for (int i = 0; i < 3; i++) begin
      fire(g);
      chk("R5 edges do not count in time mode", g, 0);
    end
    ticks(2);
    chk("R7 active before last tick", holdActive, 1);
    fire(g);
    chk("R5 discarded before last tick", g, 0);
    ticks(1);
    chk("R7 inactive after N ticks", holdActive, 0);
    fire(g);
    chk("R5 passes after N ticks", g, 1);
  endtask

  task automatic t_tie;
    logic g;
    cfg(1'b1, 16'd2);
    fire(g);
    ticks(1);
    @(negedge clk) begin tick = 1'b1; trigRaw = 1'b1; end
    @(negedge clk) g = trigOut;
    tick = 1'b0;
    trigRaw = 1'b0;
    chk("R8 edge with final tick discarded", g, 0);
    chk("R8 holdoff ended by that tick", holdActive, 0);
    @(negedge clk);
    fire(g);
    chk("R8 next edge passes", g, 1);
  endtask

  task automatic t_enable;
    logic g;
    cfg(1'b0, 16'd3);
    fire(g);
    chk("R3 armed before disable", holdActive, 1);
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    chk("R3 disable clears holdoff", holdActive, 0);
    fire(g);
    chk("R3 no pulse while disabled", g, 0);
    @(negedge clk) begin modeTime = 1'b1; holdVal = 16'd9; end
    @(negedge clk) enable = 1'b1;
    fire(g);
    chk("R3 first edge after enable passes", g, 1);
  endtask

  task automatic t_capture;
    logic g;
    cfg(1'b0, 16'd2);
    fire(g);
    @(negedge clk) holdVal = 16'd0;
    fire(g);
    chk("R9 value change ignored, discard 1", g, 0);
    fire(g);
    chk("R9 value change ignored, discard 2", g, 0);
    fire(g);
    chk("R9 passes after captured count", g, 1);
  endtask

  initial begin
    t_reset();
    t_long_high();
    t_no_hold();
    t_event();
    t_time();
    t_tie();
    t_enable();
    t_capture();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule